// File: doc/BRIEF.md
# Masked Peripheral Interrupt Collector

This block gathers up to thirty-two peripheral interrupt lines into a single request for a parent interrupt controller. Each line owns one status bit and one enable bit. Most status bits are level copies of their source, taken through one register stage. Two fixed positions, bits 10 and 11, are sticky event latches. Software clears these two by writing ones to them.

A source is pending when its status bit and its enable bit are both set. The block drives the pending vector and the position of the lowest-numbered pending source, which is the one serviced first. When nothing is pending, a valid flag reports 0, so a handler can tell a spurious request from a real one. The combined request output is the registered OR of the pending vector.

Software uses a small register port: a write enable, a byte address, write data and combinational read data. Offset 0x0 selects status and offset 0x4 selects the enable mask. Any other offset reads zero and ignores writes.

Top module: `periph_irq_agg`

## Requirements
- R1: After reset the mask reads 0x00000000, the sticky status bits (10 and 11) read 0, irq_o is 0 and idx_valid_o is 0.
- R2: A write to offset 0x4 replaces the whole 32-bit mask, and a read of offset 0x4 from the next cycle on returns exactly the written value.
- R3: Each status bit other than 10 and 11 equals its source input as sampled at the previous rising clock edge; a read of offset 0x0 returns the status register.
- R4: pending_o equals status AND mask, bit for bit; a mask bit of 1 enables its source and 0 blocks it.
- R5: When pending_o is non-zero, idx_valid_o is 1 and idx_o is the position of the least significant set bit of pending_o.
- R6: Status bits 10 and 11 set on a 0-to-1 transition of the registered source and stay set after the source returns to 0.
- R7: A write to offset 0x0 clears status bit 10 and/or 11 where the written data holds a 1; a 1 written to any other bit position, including 0xFFFFFFFF, changes neither that status bit nor the mask.
- R8: If a rising event on bit 10 or 11 coincides with a clearing write to that bit, the bit stays set.
- R9: irq_o is the OR of pending_o delayed by exactly one clock, so it falls one cycle after the last pending bit clears or is masked.
- R10: When pending_o is zero, idx_valid_o is 0 and idx_o is 0.
- R11: A read at any offset other than 0x0 and 0x4 returns zero, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Peripheral interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Combined request to the parent controller |
| pending_o | output | 32 | Status AND mask |
| idx_o | output | 5 | Lowest pending source position |
| idx_valid_o | output | 1 | Some source is pending |

## Verification
The tests drive the main function with several source patterns. Two scattered level sources under a full mask show that the lowest bit wins over a higher one. A pattern with sources at bits 1, 2 and 31 under a partial mask shows that masking moves the reported index, including onto the top position. An all-quiet pattern separates a spurious request from a real one. For the sticky bits, a single pulse shows that the latch outlives its source. An all-ones status write shows that only bits 10 and 11 react to it. A clear timed to land in the same cycle as a new edge shows which of the two has priority.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned IRQ_N       = 32;
  localparam int unsigned IRQ_ADDR_W  = 4;
  localparam logic [31:0] STICKY_BITS = 32'h0000_0C00;
  localparam logic [3:0]  OFS_STATUS  = 4'h0;
  localparam logic [3:0]  OFS_MASK    = 4'h4;

  function automatic logic [IRQ_N-1:0] edge_up(input logic [IRQ_N-1:0] now_v,
                                               input logic [IRQ_N-1:0] was_v);
    return now_v & ~was_v;
  endfunction
endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
  parameter int unsigned N_SRC = 32,
  parameter logic [N_SRC-1:0] STICKY = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] status_o,
  output logic [N_SRC-1:0] rise_o
);
  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] src_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q      <= '0;
      src_prev_q <= '0;
    end else begin
      src_q      <= src_i;
      src_prev_q <= src_q;
    end
  end

  assign rise_o = irq_agg_pkg::edge_up(src_q, src_prev_q);

  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    if (STICKY[g]) begin : g_sticky
      logic hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= rise_o[g] | (hold_q & ~clr_i[g]);
      end
      assign status_o[g] = hold_q;
    end else begin : g_level
      assign status_o[g] = src_q[g];
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);
  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o   = i[IDX_W-1:0];
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/periph_irq_agg.sv
module periph_irq_agg #(
  parameter int unsigned N_SRC  = irq_agg_pkg::IRQ_N,
  parameter int unsigned ADDR_W = irq_agg_pkg::IRQ_ADDR_W,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N_SRC-1:0]  reg_wdata,
  output logic [N_SRC-1:0]  reg_rdata,
  output logic              irq_o,
  output logic [N_SRC-1:0]  pending_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              idx_valid_o
);
  import irq_agg_pkg::*;

  localparam logic [N_SRC-1:0] STICKY = N_SRC'(STICKY_BITS);

  logic             sel_status;
  logic             sel_mask;
  logic             mask_wr;
  logic [N_SRC-1:0] clr_w;
  logic [N_SRC-1:0] status_w;
  logic [N_SRC-1:0] rise_w;
  logic [N_SRC-1:0] mask_w;

  assign sel_status = (reg_addr == ADDR_W'(OFS_STATUS));
  assign sel_mask   = (reg_addr == ADDR_W'(OFS_MASK));
  assign mask_wr    = reg_we & sel_mask;
  assign clr_w      = (reg_we & sel_status) ? (reg_wdata & STICKY) : '0;

  irq_src_capture #(.N_SRC(N_SRC), .STICKY(STICKY)) u_cap (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .clr_i(clr_w),
    .status_o(status_w), .rise_o(rise_w)
  );

  irq_mask_reg #(.N_SRC(N_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(mask_wr), .wdata_i(reg_wdata), .mask_o(mask_w)
  );

  assign pending_o = status_w & mask_w;

  irq_lowest_enc #(.N_SRC(N_SRC)) u_enc (
    .vec_i(pending_o), .idx_o(idx_o), .valid_o(idx_valid_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |pending_o;
  end

  always_comb begin
    if (sel_status)    reg_rdata = status_w;
    else if (sel_mask) reg_rdata = mask_w;
    else               reg_rdata = '0;
  end
endmodule

// File: rtl/periph_irq_agg_chk.sv
module periph_irq_agg_chk #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [N_SRC-1:0]  reg_wdata,
  input logic              irq_o,
  input logic [N_SRC-1:0]  pending_o,
  input logic [IDX_W-1:0]  idx_o,
  input logic              idx_valid_o,
  input logic [N_SRC-1:0]  stat_q,
  input logic [N_SRC-1:0]  mask_q,
  input logic [N_SRC-1:0]  rise_q
);
  logic wr_stat, wr_mask;
  assign wr_stat = reg_we && (reg_addr == ADDR_W'(0));
  assign wr_mask = reg_we && (reg_addr == ADDR_W'(4));

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(reg_wdata)));  // R2
  AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending_o & ~mask_q) == '0));  // R4
  AST_IDX_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid_o |-> pending_o[idx_o]);  // R5
  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid_o |-> ((pending_o & ((N_SRC'(1) << idx_o) - N_SRC'(1))) == '0));  // R5
  AST_HOLD_10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[10] && !(wr_stat && reg_wdata[10])) |=> stat_q[10]);  // R6
  AST_HOLD_11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[11] && !(wr_stat && reg_wdata[11])) |=> stat_q[11]);  // R6
  AST_CLEAR_10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[10] && !rise_q[10]) |=> !stat_q[10]);  // R7
  AST_EVENT_WINS_11: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q[11] |=> stat_q[11]);  // R8
  AST_IRQ_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|pending_o)));  // R9
  AST_IDLE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_valid_o |-> ((pending_o == '0) && (idx_o == '0)));  // R10
endmodule

bind periph_irq_agg periph_irq_agg_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_o(irq_o), .pending_o(pending_o), .idx_o(idx_o),
  .idx_valid_o(idx_valid_o), .stat_q(status_w), .mask_q(mask_w), .rise_q(rise_w)
);

// File: tb/tb_periph_irq_agg.sv
`timescale 1ns/1ps
module tb_periph_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  logic [31:0] pending_o;
  logic [4:0]  idx_o;
  logic        idx_valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  periph_irq_agg dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .pending_o(pending_o),
    .idx_o(idx_o), .idx_valid_o(idx_valid_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Index of lowest set bit, computed by scanning upward.
  function automatic logic [31:0] low_pos(input logic [31:0] v);
    for (int k = 0; k < 32; k++) if (v[k]) return k;
    return 0;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h4, v); check("R1 mask", v, 32'h0);
    rd(4'h0, v); check("R1 sticky", v & 32'h0C00, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1/R10 valid", {31'b0, idx_valid_o}, 32'h0);
    check("R10 idx", {27'b0, idx_o}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(4'h4, 32'hA5A5_0F0F);
    rd(4'h4, v); check("R2 readback", v, 32'hA5A5_0F0F);
    rd(4'h8, v); check("R11 read other", v, 32'h0);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h4, v); check("R11 write other", v, 32'hA5A5_0F0F);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h4, v); check("R7 status write keeps mask", v, 32'hA5A5_0F0F);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(4'h4, 32'hFFFF_FFFF);
    src_i = 32'h0000_0120;
    @(negedge clk);
    rd(4'h0, v); check("R3 status", v, 32'h0000_0120);
    check("R4 pending", pending_o, 32'h0000_0120);
    check("R5 idx", {27'b0, idx_o}, low_pos(32'h120));
    check("R5 valid", {31'b0, idx_valid_o}, 32'h1);
    check("R9 irq not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R9 irq up", {31'b0, irq_o}, 32'h1);
    src_i = '0;
    @(negedge clk);
    check("R10 valid low", {31'b0, idx_valid_o}, 32'h0);
    check("R9 irq still up", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    check("R9 irq down", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_masking();
    src_i = 32'h8000_0006;
    wr(4'h4, 32'h8000_0004);
    check("R4 masked pending", pending_o, 32'h8000_0004);
    check("R5 idx masked", {27'b0, idx_o}, 32'd2);
    wr(4'h4, 32'h8000_0000);
    check("R5 idx top", {27'b0, idx_o}, 32'd31);
    wr(4'h4, 32'h0);
    check("R4 all blocked", pending_o, 32'h0);
    @(negedge clk);
    check("R9 irq after mask", {31'b0, irq_o}, 32'h0);
    src_i = '0;
    @(negedge clk);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    wr(4'h4, 32'hFFFF_FFFF);
    src_i = 32'h0000_0401;
    @(negedge clk);
    src_i = 32'h0000_0001;
    repeat (3) @(negedge clk);
    rd(4'h0, v); check("R6 sticky 10 held", v, 32'h0000_0401);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); check("R7 clear only sticky", v, 32'h0000_0001);
    src_i = '0;
    @(negedge clk);
  endtask

  task automatic t_race();
    logic [31:0] v;
    src_i[11] = 1'b1;
    @(negedge clk);
    src_i[11] = 1'b0;
    repeat (2) @(negedge clk);
    rd(4'h0, v); check("R6 sticky 11 set", v & 32'h0800, 32'h0800);
    src_i[11] = 1'b1;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h0000_0800;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    rd(4'h0, v); check("R8 event beats clear", v & 32'h0800, 32'h0800);
    wr(4'h0, 32'h0000_0800);
    rd(4'h0, v); check("R7 clear with source high", v & 32'h0800, 32'h0);
    check("R10 idle idx", {27'b0, idx_o}, 32'h0);
    src_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_level();
    t_masking();
    t_sticky();
    t_race();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule